// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Zero, Carry and Negative Flags

This block is the purely combinational arithmetic and logic unit of a small 8-bit core. The decode stage supplies a 4-bit operation code and two operands, `opa_i` and `opb_i`, along with the current values of the zero, carry and negative flags. Within the same cycle the unit returns a result and a result-write enable. It also returns a flag-update enable and the next values of all three flags, which the caller stores in its status register.

The operations are:

- addition, subtraction and compare;
- bitwise AND, OR and XOR;
- a left or right shift of exactly one bit.

Compare subtracts `opb_i` from `opa_i` only to produce the flags, and it does not request a register write. For a compare of Rd against Rs1, the caller routes Rd to `opa_i` and Rs1 to `opb_i`. All other operation codes belong to instructions that the unit does not handle. For those codes it keeps every flag at its incoming value and requests no write.

Top module: `alu8_core`

## Requirements
- R1: Code 0x0 (add) gives result = (opa + opb) mod 256 and C = carry out of bit 7.
- R2: Code 0x1 (subtract) gives result = (opa - opb) mod 256 and C = 1 exactly when opa < opb as unsigned numbers (borrow).
- R3: Codes 0x2, 0x3 and 0x4 give the bitwise AND, OR and XOR of opa and opb, and they clear C.
- R4: Code 0x5 (shift left) gives result = {opa[6:0], 0} and C = opa[7].
- R5: Code 0x6 (shift right) gives result = {0, opa[7:1]} and C = opa[0].
- R6: Code 0xD (compare) produces the same C, Z and N as subtraction of opb from opa, and it holds the write enable low.
- R7: For every code that updates the flags, Z = 1 exactly when the 8-bit result is zero, and N equals bit 7 of the result.
- R8: The write enable is 1 for codes 0x0 through 0x6 and 0 for every other code.
- R9: The flag-update enable is 1 for codes 0x0 through 0x6 and for 0xD. For the codes 0x7 to 0xC, 0xE and 0xF it is 0, the flag outputs equal the flag inputs, and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | First operand (minuend for subtract and compare, source for shifts) |
| opb_i | input | 8 | Second operand |
| z_i | input | 1 | Current zero flag |
| c_i | input | 1 | Current carry flag |
| n_i | input | 1 | Current negative flag |
| result_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Request to write the result to the destination register |
| flag_we_o | output | 1 | Request to store the flag outputs |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| n_o | output | 1 | Next negative flag |

## Verification
The assertions are evaluated whenever the inputs change, and they take every input as a known 0 or 1. They also expect each operation code to arrive together with operands that are already settled, because a transient mix of old and new inputs is still judged by the rules for the new code. The bench therefore changes all inputs together, once per cycle, shortly after the rising clock edge. It drives only defined values, covering all sixteen codes together with the operand extremes 0x00, 0x7F, 0x80 and 0xFF. It compares the outputs on the falling edge, when the inputs are long settled.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'h0,
        OP_SUB = 4'h1,
        OP_AND = 4'h2,
        OP_OR  = 4'h3,
        OP_XOR = 4'h4,
        OP_SHL = 4'h5,
        OP_SHR = 4'h6,
        OP_CMP = 4'hD
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
    } flags_t;

    // The operation writes its result to a register.
    function automatic logic op_writes(input logic [3:0] op);
        return (op <= 4'h6);
    endfunction

    // The operation produces new flag values.
    function automatic logic op_sets_flags(input logic [3:0] op);
        return (op <= 4'h6) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    localparam int unsigned EW = W + 1;

    logic [EW-1:0] a_ext;
    logic [EW-1:0] b_ext;
    logic [EW-1:0] total;

    assign a_ext = {1'b0, a_i};
    assign b_ext = {1'b0, b_i};

    // One adder serves both directions. In subtraction, bit W of the
    // extended difference is 1 exactly when b exceeds a, which is the borrow.
    always_comb begin
        if (sub_i) total = a_ext - b_ext;
        else       total = a_ext + b_ext;
    end

    assign sum_o   = total[W-1:0];
    assign carry_o = total[W];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] y_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        always_comb begin
            unique case (sel_i)
                LG_AND:  y_o[g] = a_i[g] & b_i[g];
                LG_OR:   y_o[g] = a_i[g] | b_i[g];
                LG_XOR:  y_o[g] = a_i[g] ^ b_i[g];
                default: y_o[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         right_i,
    output logic [W-1:0] y_o,
    output logic         out_bit_o
);
    always_comb begin
        if (right_i) begin
            y_o       = {1'b0, a_i[W-1:1]};
            out_bit_o = a_i[0];
        end else begin
            y_o       = {a_i[W-2:0], 1'b0};
            out_bit_o = a_i[W-1];
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned W   = 8,
    parameter int unsigned OPW = 4
) (
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic           z_i,
    input  logic           c_i,
    input  logic           n_i,
    output logic [W-1:0]   result_o,
    output logic           wr_en_o,
    output logic           flag_we_o,
    output logic           z_o,
    output logic           c_o,
    output logic           n_o
);
    localparam int unsigned MSB = W - 1;

    logic [3:0]   op4;
    logic         is_sub;
    logic         is_right;
    logic_sel_e   lsel;
    logic [W-1:0] arith_y;
    logic         arith_c;
    logic [W-1:0] logic_y;
    logic [W-1:0] shift_y;
    logic         shift_c;
    logic [W-1:0] res;
    logic         res_c;
    flags_t       cur;
    flags_t       nxt;

    assign op4      = 4'(op_i);
    assign is_sub   = (op4 == OP_SUB) || (op4 == OP_CMP);
    assign is_right = (op4 == OP_SHR);
    assign cur      = '{z: z_i, c: c_i, n: n_i};

    always_comb begin
        unique case (op4)
            OP_OR:   lsel = LG_OR;
            OP_XOR:  lsel = LG_XOR;
            default: lsel = LG_AND;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .sub_i   (is_sub),
        .sum_o   (arith_y),
        .carry_o (arith_c)
    );

    alu8_logic #(.W(W)) u_logic (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .sel_i (lsel),
        .y_o   (logic_y)
    );

    alu8_shift #(.W(W)) u_shift (
        .a_i       (opa_i),
        .right_i   (is_right),
        .y_o       (shift_y),
        .out_bit_o (shift_c)
    );

    always_comb begin
        case (op4)
            OP_ADD, OP_SUB, OP_CMP: begin
                res   = arith_y;
                res_c = arith_c;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res   = logic_y;
                res_c = 1'b0;
            end
            OP_SHL, OP_SHR: begin
                res   = shift_y;
                res_c = shift_c;
            end
            default: begin
                res   = '0;
                res_c = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (op_sets_flags(op4)) begin
            nxt.z = (res == '0);
            nxt.c = res_c;
            nxt.n = res[MSB];
        end else begin
            nxt = cur;
        end
    end

    assign result_o  = res;
    assign wr_en_o   = op_writes(op4);
    assign flag_we_o = op_sets_flags(op4);
    assign z_o       = nxt.z;
    assign c_o       = nxt.c;
    assign n_o       = nxt.n;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int unsigned W   = 8,
    parameter int unsigned OPW = 4
) (
    input logic [OPW-1:0] op_i,
    input logic [W-1:0]   opa_i,
    input logic [W-1:0]   opb_i,
    input logic           z_i,
    input logic           c_i,
    input logic           n_i,
    input logic [W-1:0]   result_o,
    input logic           wr_en_o,
    input logic           flag_we_o,
    input logic           z_o,
    input logic           c_o,
    input logic           n_o
);
    logic [W:0] add_ref;
    assign add_ref = {1'b0, opa_i} + {1'b0, opb_i};

    always_comb begin
        if (op_i == 'h0) begin
            a_r1_add_carry: assert ({c_o, result_o} == add_ref)
                else $error("add sum or carry wrong");
        end
        if (op_i == 'h1 || op_i == 'hD) begin
            a_r2_borrow: assert (c_o == (opa_i < opb_i))
                else $error("borrow wrong");
        end
        if (op_i == 'h2 || op_i == 'h3 || op_i == 'h4) begin
            a_r3_logic_clears_c: assert (!c_o)
                else $error("logic op left carry set");
        end
        if (op_i == 'h5) begin
            a_r4_shl: assert (result_o == (opa_i << 1) && c_o == opa_i[W-1])
                else $error("left shift wrong");
        end
        if (op_i == 'h6) begin
            a_r5_shr: assert (result_o == (opa_i >> 1) && c_o == opa_i[0])
                else $error("right shift wrong");
        end
        if (op_i == 'hD) begin
            a_r6_cmp_no_write: assert (!wr_en_o && flag_we_o)
                else $error("compare enables wrong");
        end
        if (flag_we_o) begin
            a_r7_zero_neg: assert (z_o == (result_o == '0) && n_o == result_o[W-1])
                else $error("zero or negative flag wrong");
        end
        a_r8_write_implies_flags: assert (!wr_en_o || flag_we_o)
            else $error("write without flag update");
        if (!flag_we_o) begin
            a_r9_flags_hold: assert (z_o == z_i && c_o == c_i && n_o == n_i && result_o == '0)
                else $error("flags not held on idle code");
        end
    end
endmodule

bind alu8_core alu8_core_chk #(.W(W), .OPW(OPW)) u_chk (
    .op_i      (op_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .z_i       (z_i),
    .c_i       (c_i),
    .n_i       (n_i),
    .result_o  (result_o),
    .wr_en_o   (wr_en_o),
    .flag_we_o (flag_we_o),
    .z_o       (z_o),
    .c_o       (c_o),
    .n_o       (n_o)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
    logic       clk = 1'b0;
    logic [3:0] op;
    logic [7:0] a, b;
    logic       zi, ci, ni;
    logic [7:0] res;
    logic       we, fwe, zo, co, no;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    alu8_core dut (
        .op_i(op), .opa_i(a), .opb_i(b), .z_i(zi), .c_i(ci), .n_i(ni),
        .result_o(res), .wr_en_o(we), .flag_we_o(fwe),
        .z_o(zo), .c_o(co), .n_o(no)
    );

    function automatic string tag_for(input int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R3";
            5: return "R4";
            6: return "R5";
            13: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s op=%0h a=%0h b=%0h actual=%0h expected=%0h",
                     tag, what, op, a, b, act, exp);
        end
    endtask

    task automatic apply(input int o, input int x, input int y, input int fz, input int fc, input int fn);
        int e_res, e_c, e_z, e_n, e_we, e_fwe, tmp;
        @(posedge clk);
        #2;
        op = 4'(o); a = 8'(x); b = 8'(y);
        zi = 1'(fz); ci = 1'(fc); ni = 1'(fn);
        @(negedge clk);
        e_we  = (o <= 6) ? 1 : 0;
        e_fwe = (o <= 6 || o == 13) ? 1 : 0;
        e_c   = 0;
        case (o)
            0: begin tmp = x + y; e_res = tmp % 256; e_c = (tmp > 255) ? 1 : 0; end
            1, 13: begin e_res = (x - y + 256) % 256; e_c = (x < y) ? 1 : 0; end
            2: e_res = x & y;
            3: e_res = x | y;
            4: e_res = x ^ y;
            5: begin e_res = (x * 2) % 256; e_c = x / 128; end
            6: begin e_res = x / 2; e_c = x % 2; end
            default: e_res = 0;
        endcase
        if (e_fwe == 1) begin
            e_z = (e_res == 0) ? 1 : 0;
            e_n = e_res / 128;
        end else begin
            e_z = fz; e_c = fc; e_n = fn;
        end
        if (o == 13) check("R6", "cmp wr_en", int'(we), 0);
        check(tag_for(o), "result", int'(res), e_res);
        check(tag_for(o), "carry", int'(co), e_c);
        check("R7", "zero", int'(zo), e_z);
        check("R7", "neg", int'(no), e_n);
        check("R8", "wr_en", int'(we), e_we);
        check("R9", "flag_we", int'(fwe), e_fwe);
    endtask

    initial begin
        op = '0; a = '0; b = '0; zi = 0; ci = 0; ni = 0;
        // Quiescent inputs: add of zeros, zero flag set (R1, R7)
        apply(0, 0, 0, 0, 0, 0);
        // R1 carry corners
        apply(0, 255, 1, 0, 0, 0);
        apply(0, 128, 128, 0, 0, 0);
        apply(0, 127, 1, 0, 0, 0);
        apply(0, 255, 255, 0, 0, 0);
        // R2 borrow corners
        apply(1, 0, 1, 0, 0, 0);
        apply(1, 5, 5, 0, 0, 0);
        apply(1, 128, 127, 0, 0, 0);
        // R3 logic clears carry even with carry set on input
        apply(2, 240, 15, 0, 1, 0);
        apply(3, 128, 1, 0, 1, 0);
        apply(4, 170, 170, 0, 1, 0);
        // R4 / R5 shift-out carry
        apply(5, 128, 0, 0, 0, 0);
        apply(5, 127, 0, 0, 0, 0);
        apply(6, 1, 0, 0, 0, 0);
        apply(6, 254, 0, 0, 0, 0);
        // R6 compare equal, less, greater
        apply(13, 10, 10, 0, 0, 0);
        apply(13, 9, 10, 0, 0, 0);
        apply(13, 200, 3, 1, 1, 1);
        // R9 idle codes hold both flag patterns
        for (int o = 7; o < 16; o++) begin
            if (o != 13) begin
                apply(o, 255, 255, 1, 0, 1);
                apply(o, 0, 0, 0, 1, 0);
            end
        end
        // Pseudo-random sweep over all codes
        for (int k = 0; k < 40; k++) begin
            for (int o = 0; o < 16; o++) begin
                apply(o, int'($urandom_range(255)), int'($urandom_range(255)),
                      int'($urandom_range(1)), int'($urandom_range(1)), int'($urandom_range(1)));
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule